// File: doc/BRIEF.md
# Addressable serial DAC load interface

This block is the digital front end of a four-channel converter. A 16-bit word arrives on a serial data line. Each bit is taken on a falling edge of a serial clock, and a frame begins when an active-low sync strobe falls. The most significant bit of the shift register drives a serial data output. The next device in a chain can take that output as its own serial input.

When the sixteenth bit of a frame lands, the block compares the word's two device-address bits with two strap inputs. A word that matches writes a 12-bit code into one of four input latches. A word that does not match is dropped. A falling edge on the load strobe copies all four input latches into the DAC latches at once. The DAC latches drive the outputs. A low level on the clear input forces every DAC latch to zero and leaves the input latches alone, so a later load brings the old codes back.

All serial and strobe inputs are resampled into the system clock domain. The serial clock must therefore run several times slower than the system clock. The strap inputs are treated as static.

Top module: `addr_serial_dac_front`

## Requirements
- R1: After reset, all four channel codes on `dac_code` and the serial output `sdo` are zero.
- R2: Serial bits are taken on falling `sclk` edges, most significant bit first. Word bits 15..4 carry the 12-bit code with bit 15 as its MSB. Every code from 0 to 4095 can be loaded.
- R3: `sdo` equals the bit that was shifted in 16 falling `sclk` edges earlier, or zero if fewer edges have occurred since reset. It changes only on a falling `sclk` edge.
- R4: A completed word is accepted only when its bits 3..2 equal `addr_strap[1:0]`. A word that does not match leaves every input latch unchanged.
- R5: Bits 1..0 of an accepted word select the channel to write. Channel n occupies `dac_code[12*n+11 : 12*n]`.
- R6: Writing an input latch does not change `dac_code` until a load occurs.
- R7: A falling edge on `ld_n` updates all four channel outputs in the same cycle from their input latches.
- R8: While `clr_n` is low, every channel output is zero. The input latches keep their contents, so a later load restores the earlier codes.
- R9: When `clr_n` and `ld_n` are both low, clear wins and the outputs stay zero.
- R10: A falling `fsync_n` restarts the bit count, and only the 16th falling `sclk` edge after it evaluates a word. A new sync before that edge discards a partial word. Edges after the 16th shift data toward `sdo` but write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock, data taken on its falling edge |
| fsync_n | input | 1 | Active-low frame sync, a falling edge starts a word |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, MSB of the shift register |
| addr_strap | input | 2 | Device address straps compared with word bits 3..2 |
| ld_n | input | 1 | Active-low load strobe, acts on its falling edge |
| clr_n | input | 1 | Active-low clear level for the DAC latches |
| dac_code | output | 48 | Four 12-bit DAC latch codes, channel 0 in the low bits |

## Verification
Four properties are checked on every cycle. The outputs hold between loads. A load copies all four input latches in one step. Clear zeroes the outputs even during a load. The input latches and `sdo` hold when no write or serial edge occurs. The bench's scenarios are needed for the rest: address matching across every strap and address pair, channel routing, the MSB-first field layout and its boundary codes, the daisy-chain delay through sixteen edges, partial frames cut off by a new sync, and extra clocks that must not decode.

// File: rtl/sdac_pkg.sv
// Shared widths and the write-request type for the serial DAC front end.
// Assumes the word splits exactly into code, address and channel fields.
package sdac_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 12;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 2;
    localparam int SEL_W  = $clog2(NUM_CH);

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  ch;
        logic [CODE_W-1:0] code;
    } wr_req_t;
endpackage

// File: rtl/sdac_sync.sv
// Multi-stage resynchroniser for a bundle of asynchronous level inputs.
// Assumes every bit is an independent level whose exact alignment with the others does not matter.
module sdac_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_frame_rx.sv
// Serial word receiver: shifts on falling serial clock edges, counts bits
// after a sync, and checks address on the last bit, emitting one write request.
// Assumes all inputs are already in the clk domain and the serial clock is
// slow enough that each of its levels spans at least one clk cycle.
module sdac_frame_rx #(
    parameter int WORD_W = sdac_pkg::WORD_W,
    parameter int CODE_W = sdac_pkg::CODE_W,
    parameter int ADDR_W = sdac_pkg::ADDR_W,
    parameter int SEL_W  = sdac_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              fsync_s,
    input  logic              sdin_s,
    input  logic [ADDR_W-1:0] addr_strap,
    output logic              sdo,
    output logic              sclk_fall,
    output sdac_pkg::wr_req_t wr_req
);
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int ADDR_LSB = SEL_W;
    localparam int CODE_LSB = SEL_W + ADDR_W;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic              sclk_q;
    logic              fsync_q;
    logic              frame_start;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shift_nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic              armed;
    logic              last_bit;
    logic              addr_hit;

    // Keep the previous serial clock and sync levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b1;
            fsync_q <= 1'b1;
        end else begin
            sclk_q  <= sclk_s;
            fsync_q <= fsync_s;
        end
    end

    assign sclk_fall   = sclk_q & ~sclk_s;
    assign frame_start = fsync_q & ~fsync_s;
    assign shift_nxt   = {shreg[WORD_W-2:0], sdin_s};
    assign last_bit    = armed && sclk_fall && !frame_start && (bit_cnt == LAST_IDX);
    assign addr_hit    = (shift_nxt[ADDR_LSB +: ADDR_W] == addr_strap);

    // Input shift register: moves on every falling serial edge, framed or not.
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg <= '0;
        else if (sclk_fall) shreg <= shift_nxt;
    end

    // Bit counter: restarted by sync, disarmed after the last bit of a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            armed   <= 1'b0;
        end else if (frame_start) begin
            bit_cnt <= '0;
            armed   <= 1'b1;
        end else if (sclk_fall && armed) begin
            if (bit_cnt == LAST_IDX) begin
                bit_cnt <= '0;
                armed   <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Write request: one pulse per completed word whose address matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req <= '0;
        end else begin
            wr_req.en <= last_bit && addr_hit;
            if (last_bit) begin
                wr_req.ch   <= shift_nxt[SEL_W-1:0];
                wr_req.code <= shift_nxt[CODE_LSB +: CODE_W];
            end
        end
    end

    assign sdo = shreg[WORD_W-1];
endmodule

// File: rtl/sdac_latch_bank.sv
// Double-buffered channel storage: per-channel input latch written by a
// request, and DAC latches loaded together on a load pulse or zeroed by clear.
// Assumes ld_fall is a single-cycle pulse and clr_lvl_n a synchronous level.
module sdac_latch_bank #(
    parameter int NUM_CH = sdac_pkg::NUM_CH,
    parameter int CODE_W = sdac_pkg::CODE_W,
    parameter int SEL_W  = sdac_pkg::SEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_ch,
    input  logic [CODE_W-1:0]        wr_code,
    input  logic                     ld_fall,
    input  logic                     clr_lvl_n,
    output logic [NUM_CH*CODE_W-1:0] inp_all,
    output logic [NUM_CH*CODE_W-1:0] dac_all
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CODE_W-1:0] inp_q;
        logic [CODE_W-1:0] dac_q;

        // Input latch: takes the code when this channel is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                              inp_q <= '0;
            else if (wr_en && wr_ch == SEL_W'(g))    inp_q <= wr_code;
        end

        // DAC latch: clear first, then the common load.
        always_ff @(posedge clk) begin
            if (!rst_n)          dac_q <= '0;
            else if (!clr_lvl_n) dac_q <= '0;
            else if (ld_fall)    dac_q <= inp_q;
        end

        assign inp_all[g*CODE_W +: CODE_W] = inp_q;
        assign dac_all[g*CODE_W +: CODE_W] = dac_q;
    end
endmodule

// File: rtl/addr_serial_dac_front.sv
// Top of the serial DAC front end: resamples the serial and strobe pins,
// receives addressed words and drives four double-buffered channel codes.
// Assumes addr_strap is static while frames are in flight.
module addr_serial_dac_front #(
    parameter int NUM_CH      = sdac_pkg::NUM_CH,
    parameter int CODE_W      = sdac_pkg::CODE_W,
    parameter int ADDR_W      = sdac_pkg::ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     fsync_n,
    input  logic                     sdin,
    output logic                     sdo,
    input  logic [ADDR_W-1:0]        addr_strap,
    input  logic                     ld_n,
    input  logic                     clr_n,
    output logic [NUM_CH*CODE_W-1:0] dac_code
);
    localparam int SEL_W = $clog2(NUM_CH);

    logic [3:0]               ctl_s;
    logic                     sdin_s;
    logic                     sclk_s;
    logic                     fsync_s;
    logic                     ld_s;
    logic                     clr_s;
    logic                     ld_q;
    logic                     ld_fall;
    logic                     sclk_fall;
    logic                     wr_en;
    logic [NUM_CH*CODE_W-1:0] inp_all;
    sdac_pkg::wr_req_t        wr;

    sdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clr_n, ld_n, fsync_n, sclk}),
        .q     (ctl_s)
    );

    sdac_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sdin),
        .q     (sdin_s)
    );

    assign {clr_s, ld_s, fsync_s, sclk_s} = ctl_s;

    // Previous load level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= 1'b1;
        else        ld_q <= ld_s;
    end

    assign ld_fall = ld_q & ~ld_s;

    sdac_frame_rx #(
        .WORD_W (CODE_W + ADDR_W + SEL_W),
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .fsync_s    (fsync_s),
        .sdin_s     (sdin_s),
        .addr_strap (addr_strap),
        .sdo        (sdo),
        .sclk_fall  (sclk_fall),
        .wr_req     (wr)
    );

    assign wr_en = wr.en;

    sdac_latch_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (wr.ch),
        .wr_code   (wr.code),
        .ld_fall   (ld_fall),
        .clr_lvl_n (clr_s),
        .inp_all   (inp_all),
        .dac_all   (dac_code)
    );
endmodule

// File: rtl/sdac_checker.sv
// Cycle-level properties of the serial DAC front end, bound to the top.
module sdac_checker #(
    parameter int NUM_CH = sdac_pkg::NUM_CH,
    parameter int CODE_W = sdac_pkg::CODE_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sclk_fall,
    input logic                     sdo,
    input logic                     clr_lvl_n,
    input logic                     ld_fall,
    input logic                     wr_en,
    input logic [NUM_CH*CODE_W-1:0] inp_all,
    input logic [NUM_CH*CODE_W-1:0] dac_all
);
    // R6: outputs move only on a load or a clear.
    p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_fall && clr_lvl_n) |=> $stable(dac_all));

    // R7: one load copies every input latch at once.
    p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fall && clr_lvl_n) |=> (dac_all == $past(inp_all)));

    // R8: clear level gives zero outputs.
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl_n |=> (dac_all == '0));

    // R9: clear overrides a simultaneous load.
    p_clr_over_ld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_lvl_n && ld_fall) |=> (dac_all == '0));

    // R4: input latches only change on an accepted write.
    p_input_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(inp_all));

    // R8: clearing leaves the input latches untouched.
    p_clr_keeps_inp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_lvl_n && !wr_en) |=> $stable(inp_all));

    // R3: serial output only changes on a falling serial edge.
    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo));
endmodule

bind addr_serial_dac_front sdac_checker u_sdac_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_fall (sclk_fall),
    .sdo       (sdo),
    .clr_lvl_n (clr_s),
    .ld_fall   (ld_fall),
    .wr_en     (wr_en),
    .inp_all   (inp_all),
    .dac_all   (dac_code)
);

// File: tb/test_addr_serial_dac_front.sv
module test_addr_serial_dac_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        fsync_n = 1'b1;
    logic        sdin = 1'b0;
    logic        sdo;
    logic [1:0]  addr_strap = 2'd0;
    logic        ld_n = 1'b1;
    logic        clr_n = 1'b1;
    logic [47:0] dac_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [11:0] inp_m [4];
    logic [11:0] dac_m [4];
    logic [15:0] sh_m = '0;

    always #2 clk = ~clk;

    addr_serial_dac_front i_addr_serial_dac_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .fsync_n    (fsync_n),
        .sdin       (sdin),
        .sdo        (sdo),
        .addr_strap (addr_strap),
        .ld_n       (ld_n),
        .clr_n      (clr_n),
        .dac_code   (dac_code)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkw(input int code, input int a, input int c);
        return {code[11:0], a[1:0], c[1:0]};
    endfunction

    // Send bits MSB first from bit 15 down; sdo checked after each falling edge (R3).
    task automatic send_bits(input logic [15:0] w, input int nbits);
        for (int k = 15; k > 15 - nbits; k--) begin
            sdin = w[k];
            tick(4);
            sclk = 1'b0;
            sh_m = {sh_m[14:0], w[k]};
            tick(4);
            check(sdo == sh_m[15], "R3 sdo", {15'd0, sdo}, {15'd0, sh_m[15]});
            sclk = 1'b1;
        end
    endtask

    // Full framed word; model accepts it only on address match (R4, R5).
    task automatic frame(input logic [15:0] w);
        fsync_n = 1'b0;
        tick(4);
        send_bits(w, 16);
        fsync_n = 1'b1;
        tick(6);
        if (w[3:2] == addr_strap) inp_m[w[1:0]] = w[15:4];
    endtask

    task automatic pulse_load();
        ld_n = 1'b0;
        tick(6);
        ld_n = 1'b1;
        tick(6);
        if (clr_n) for (int c = 0; c < 4; c++) dac_m[c] = inp_m[c];
    endtask

    task automatic check_dac(input string req);
        for (int c = 0; c < 4; c++)
            check(dac_code[c*12 +: 12] == dac_m[c], req,
                  {4'd0, dac_code[c*12 +: 12]}, {4'd0, dac_m[c]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin inp_m[c] = '0; dac_m[c] = '0; end
        tick(10);
        rst_n = 1'b1;
        tick(4);
        // R1: reset state
        check_dac("R1 reset dac");
        check(sdo == 1'b0, "R1 reset sdo", {15'd0, sdo}, 16'd0);

        // R4 R5 R6 R7 R2: sweep every strap, word address and channel
        for (int s = 0; s < 4; s++) begin
            addr_strap = s[1:0];
            tick(2);
            for (int a = 0; a < 4; a++) begin
                for (int c = 0; c < 4; c++)
                    frame(mkw((s * 1021 + a * 257 + c * 73 + 5) % 4096, a, c));
                check_dac("R6 no change before load");
                pulse_load();
                check_dac("R4 R5 R7 after load");
            end
        end

        // R2: boundary codes
        addr_strap = 2'd2;
        tick(2);
        frame(mkw(4095, 2, 0));
        frame(mkw(0, 2, 1));
        frame(mkw(2048, 2, 2));
        frame(mkw(2047, 2, 3));
        pulse_load();
        check_dac("R2 boundary codes");

        // R10 R3: extra clocks after a word shift through but do not decode
        addr_strap = 2'd1;
        tick(2);
        frame(mkw(12'hA5C, 1, 2));
        send_bits(mkw(12'h3FF, 1, 3), 16);
        tick(6);
        pulse_load();
        check_dac("R10 extra clocks ignored");

        // R10: partial word cut by a new sync is dropped
        fsync_n = 1'b0;
        tick(4);
        send_bits(mkw(12'h111, 1, 0), 10);
        fsync_n = 1'b1;
        tick(4);
        frame(mkw(12'h6B3, 1, 1));
        pulse_load();
        check_dac("R10 partial frame");

        // R8: clear zeroes outputs, load restores
        clr_n = 1'b0;
        tick(6);
        for (int c = 0; c < 4; c++) dac_m[c] = '0;
        check_dac("R8 clear");
        clr_n = 1'b1;
        tick(6);
        check_dac("R8 stays zero after clear");
        pulse_load();
        check_dac("R8 load restores");

        // R9: clear beats a simultaneous load
        clr_n = 1'b0;
        ld_n = 1'b0;
        tick(6);
        ld_n = 1'b1;
        tick(6);
        for (int c = 0; c < 4; c++) dac_m[c] = '0;
        check_dac("R9 clear priority");
        clr_n = 1'b1;
        tick(6);
        check_dac("R9 zero after release");
        pulse_load();
        check_dac("R9 restore");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule